// File: doc/BRIEF.md
# Indirect Jump Target Resolver

This block works out where an indirect jump lands on an 8-bit processor with a 16-bit address space. When started, it fetches the two operand bytes that follow the opcode and reads them through a synchronous byte-wide read port. It joins them into a pointer, reads the 16-bit destination from the pointer location in little-endian order, and returns the destination as the new program counter.

A mode input picks how the address of the destination's upper byte is formed. In legacy mode, only the low byte of the pointer steps forward, so a pointer that ends in FF takes its upper byte from the start of the same 256-byte page. In corrected mode, the step is a full 16-bit increment. An indexed input adds an 8-bit index register to the operand pointer before the destination is read. This supports jump tables. The indexed form always uses the corrected increment. Corrected mode spends one internal cycle on the increment, and the indexed form spends one cycle on the index add.

Top module: `ind_jump_resolver`

## Requirements
- R1: After reset, busy_o, done_o and mem_rd_o are all low, and the port issues no read until a start is accepted.
- R2: A start_i sampled while idle is accepted. The block then reads op_addr_i and op_addr_i+1, using a full 16-bit increment even across FFFF. The first byte read is the pointer's low byte and the second byte read is its high byte.
- R3: The low byte of the destination is read at the pointer. pc_o is {upper byte, low byte} in the cycle in which done_o is high.
- R4: In legacy mode (fix_mode_i=0, indexed_i=0), the upper byte is read at {pointer[15:8], pointer[7:0]+1 mod 256}, so pointer xxFF reads from xx00.
- R5: In corrected mode (fix_mode_i=1), the upper byte is read at pointer+1 with a full 16-bit carry, so pointer xxFF reads from (xx+1)00.
- R6: With indexed_i=1, the pointer is the operand pointer plus the zero-extended index_i with a full carry. The corrected increment is used whatever the value of fix_mode_i.
- R7: Count the clock edge that samples start_i as edge 1. done_o is high after edge 6 in legacy mode, after edge 7 in corrected mode, and after edge 8 in the indexed form.
- R8: done_o is high for exactly one cycle and busy_o is low in that cycle. busy_o is high from the edge after acceptance until done_o rises.
- R9: A start_i sampled while busy has no effect on pc_o, on the latency or on the reads issued.
- R10: A start_i given in the cycle in which done_o is high is accepted. The second operation then completes with its own result.
- R11: mem_rd_o is high only while busy, and each operation issues exactly four reads: two operand bytes and two destination bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to resolve a jump, sampled while idle |
| op_addr_i | input | 16 | Address of the first operand byte after the opcode |
| fix_mode_i | input | 1 | 1 selects the full-carry increment, 0 selects the in-page wrap |
| indexed_i | input | 1 | 1 adds index_i to the operand pointer |
| index_i | input | 8 | Index register value for the indexed form |
| mem_rd_o | output | 1 | Read strobe, one byte per cycle |
| mem_addr_o | output | 16 | Read address |
| mem_data_i | input | 8 | Read data, valid the cycle after the strobe |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse with pc_o valid |
| pc_o | output | 16 | Resolved destination |

## Verification
The completion pulse and the acceptance of the next request can fall in the same cycle, because the block is already idle when done_o rises. The bench drives start_i with a new operand address in exactly the cycle in which it sees done_o. It then checks that the first result was presented intact, and that the second operation reports its own destination after the full latency. A start driven in the middle of a busy operation is judged in the same way: the result, the latency and the read count of the running operation must stay unchanged.

// File: rtl/ijr_pkg.sv
package ijr_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_OPLO = 3'd1,
    S_OPHI = 3'd2,
    S_IDX  = 3'd3,
    S_RDLO = 3'd4,
    S_BUMP = 3'd5,
    S_RDHI = 3'd6,
    S_FIN  = 3'd7
  } ijr_state_e;
endpackage

// File: rtl/ijr_seq.sv
module ijr_seq
  import ijr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       idx_q_i,
  input  logic       fix_q_i,
  output ijr_state_e state_o,
  output logic       accept_o
);
  ijr_state_e st_q, st_d;

  assign accept_o = (st_q == S_IDLE) && start_i;
  assign state_o  = st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE: if (start_i) st_d = S_OPLO;
      S_OPLO: st_d = S_OPHI;
      S_OPHI: st_d = idx_q_i ? S_IDX : S_RDLO;
      S_IDX:  st_d = S_RDLO;
      S_RDLO: st_d = fix_q_i ? S_BUMP : S_RDHI;
      S_BUMP: st_d = S_RDHI;
      S_RDHI: st_d = S_FIN;
      S_FIN:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/ijr_addr.sv
module ijr_addr
  import ijr_pkg::*;
#(
  parameter int DW = 8
) (
  input  ijr_state_e       state_i,
  input  logic [2*DW-1:0]  op_q_i,
  input  logic [2*DW-1:0]  ptr_q_i,
  input  logic [DW-1:0]    lo_q_i,
  input  logic [DW-1:0]    index_q_i,
  input  logic [DW-1:0]    bus_i,
  input  logic             idx_q_i,
  input  logic             fix_q_i,
  output logic             rd_o,
  output logic [2*DW-1:0]  addr_o,
  output logic [2*DW-1:0]  idx_sum_o,
  output logic [2*DW-1:0]  bump_o
);
  localparam int AW = 2 * DW;

  logic [AW-1:0] joined;
  logic [DW-1:0] lo_step;
  logic [AW-1:0] op_next;

  assign joined    = {bus_i, lo_q_i};
  assign lo_step   = ptr_q_i[DW-1:0] + {{(DW-1){1'b0}}, 1'b1};
  assign op_next   = op_q_i + {{(AW-1){1'b0}}, 1'b1};
  assign idx_sum_o = joined + {{DW{1'b0}}, index_q_i};
  assign bump_o    = ptr_q_i + {{(AW-1){1'b0}}, 1'b1};

  always_comb begin
    rd_o   = 1'b0;
    addr_o = ptr_q_i;
    unique case (state_i)
      S_OPLO: begin
        rd_o   = 1'b1;
        addr_o = op_q_i;
      end
      S_OPHI: begin
        rd_o   = 1'b1;
        addr_o = op_next;
      end
      S_RDLO: begin
        rd_o   = 1'b1;
        addr_o = idx_q_i ? ptr_q_i : joined;
      end
      S_RDHI: begin
        rd_o   = 1'b1;
        addr_o = fix_q_i ? ptr_q_i : {ptr_q_i[AW-1:DW], lo_step};
      end
      default: begin
        rd_o   = 1'b0;
        addr_o = ptr_q_i;
      end
    endcase
  end
endmodule

// File: rtl/ijr_hold.sv
module ijr_hold
  import ijr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ijr_state_e       state_i,
  input  logic             accept_i,
  input  logic [2*DW-1:0]  op_addr_i,
  input  logic             fix_mode_i,
  input  logic             indexed_i,
  input  logic [DW-1:0]    index_i,
  input  logic [DW-1:0]    bus_i,
  input  logic [2*DW-1:0]  addr_i,
  input  logic [2*DW-1:0]  idx_sum_i,
  input  logic [2*DW-1:0]  bump_i,
  output logic [2*DW-1:0]  op_q_o,
  output logic [2*DW-1:0]  ptr_q_o,
  output logic [DW-1:0]    lo_q_o,
  output logic [DW-1:0]    index_q_o,
  output logic             idx_q_o,
  output logic             fix_q_o,
  output logic [2*DW-1:0]  pc_o,
  output logic             done_o
);
  localparam int AW = 2 * DW;

  logic          lo_en, ptr_en, adl_en, pc_en;
  logic [AW-1:0] ptr_d;
  logic [DW-1:0] adl_q;

  assign lo_en  = (state_i == S_OPHI);
  assign ptr_en = (state_i == S_IDX) || (state_i == S_RDLO) || (state_i == S_BUMP);
  assign adl_en = (state_i == S_BUMP) || ((state_i == S_RDHI) && !fix_q_o);
  assign pc_en  = (state_i == S_FIN);

  always_comb begin
    unique case (state_i)
      S_IDX:   ptr_d = idx_sum_i;
      S_BUMP:  ptr_d = bump_i;
      default: ptr_d = addr_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q_o    <= '0;
      fix_q_o   <= 1'b0;
      idx_q_o   <= 1'b0;
      index_q_o <= '0;
    end else if (accept_i) begin
      op_q_o    <= op_addr_i;
      fix_q_o   <= fix_mode_i | indexed_i;
      idx_q_o   <= indexed_i;
      index_q_o <= index_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q_o <= '0;
    else if (lo_en) lo_q_o <= bus_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q_o <= '0;
    else if (ptr_en) ptr_q_o <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      adl_q <= '0;
    else if (adl_en) adl_q <= bus_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_o <= '0;
    else if (pc_en) pc_o <= {bus_i, adl_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_o <= 1'b0;
    else        done_o <= pc_en;
  end
endmodule

// File: rtl/ind_jump_resolver.sv
module ind_jump_resolver
  import ijr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2*DW-1:0]   op_addr_i,
  input  logic              fix_mode_i,
  input  logic              indexed_i,
  input  logic [DW-1:0]     index_i,
  output logic              mem_rd_o,
  output logic [2*DW-1:0]   mem_addr_o,
  input  logic [DW-1:0]     mem_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2*DW-1:0]   pc_o
);
  localparam int AW = 2 * DW;

  logic          rst_meta, rst_q;
  ijr_state_e    st;
  logic          accept;
  logic [AW-1:0] op_q, ptr_q, idx_sum, bump;
  logic [DW-1:0] lo_q, index_q;
  logic          idx_q, fix_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  ijr_seq i_seq (
    .clk      (clk),
    .rst_n    (rst_q),
    .start_i  (start_i),
    .idx_q_i  (idx_q),
    .fix_q_i  (fix_q),
    .state_o  (st),
    .accept_o (accept)
  );

  ijr_addr #(.DW(DW)) i_addr (
    .state_i   (st),
    .op_q_i    (op_q),
    .ptr_q_i   (ptr_q),
    .lo_q_i    (lo_q),
    .index_q_i (index_q),
    .bus_i     (mem_data_i),
    .idx_q_i   (idx_q),
    .fix_q_i   (fix_q),
    .rd_o      (mem_rd_o),
    .addr_o    (mem_addr_o),
    .idx_sum_o (idx_sum),
    .bump_o    (bump)
  );

  ijr_hold #(.DW(DW)) i_hold (
    .clk        (clk),
    .rst_n      (rst_q),
    .state_i    (st),
    .accept_i   (accept),
    .op_addr_i  (op_addr_i),
    .fix_mode_i (fix_mode_i),
    .indexed_i  (indexed_i),
    .index_i    (index_i),
    .bus_i      (mem_data_i),
    .addr_i     (mem_addr_o),
    .idx_sum_i  (idx_sum),
    .bump_i     (bump),
    .op_q_o     (op_q),
    .ptr_q_o    (ptr_q),
    .lo_q_o     (lo_q),
    .index_q_o  (index_q),
    .idx_q_o    (idx_q),
    .fix_q_o    (fix_q),
    .pc_o       (pc_o),
    .done_o     (done_o)
  );

  assign busy_o = (st != S_IDLE);
endmodule

// File: rtl/ijr_chk.sv
module ijr_chk
  import ijr_pkg::*;
#(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_q,
  input ijr_state_e      st,
  input logic            fix_q,
  input logic            mem_rd_o,
  input logic [2*DW-1:0] mem_addr_o,
  input logic            busy_o,
  input logic            done_o
);
  a_r1_no_read_idle: assert property (@(posedge clk) disable iff (!rst_q)
    !busy_o |-> !mem_rd_o);

  a_r11_read_only_busy: assert property (@(posedge clk) disable iff (!rst_q)
    mem_rd_o |-> busy_o);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_q)
    done_o |=> !done_o);

  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_q)
    done_o |-> !busy_o);

  a_r4_page_wrap: assert property (@(posedge clk) disable iff (!rst_q)
    (st == S_RDHI && !fix_q) |->
      (mem_addr_o == {$past(mem_addr_o[2*DW-1:DW]), $past(mem_addr_o[DW-1:0]) + {{(DW-1){1'b0}}, 1'b1}}));

  a_r5_full_carry: assert property (@(posedge clk) disable iff (!rst_q)
    (st == S_RDHI && fix_q && $past(st) == S_BUMP) |->
      (mem_addr_o == $past(mem_addr_o, 2) + {{(2*DW-1){1'b0}}, 1'b1}));

  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_q)
    (busy_o && st != S_FIN) |=> busy_o);
endmodule

bind ind_jump_resolver ijr_chk #(.DW(DW)) i_chk (
  .clk        (clk),
  .rst_q      (rst_q),
  .st         (st),
  .fix_q      (fix_q),
  .mem_rd_o   (mem_rd_o),
  .mem_addr_o (mem_addr_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/test_ind_jump_resolver.sv
module test_ind_jump_resolver;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] op_addr_i = '0;
  logic        fix_mode_i = 1'b0;
  logic        indexed_i = 1'b0;
  logic [7:0]  index_i = '0;
  logic        mem_rd_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_data_i;
  logic        busy_o, done_o;
  logic [15:0] pc_o;

  logic [7:0]  mem [0:65535];
  int          total = 0;
  int          bad = 0;
  int          reads = 0;

  always #(PERIOD/2) clk = ~clk;

  ind_jump_resolver i_ind_jump_resolver (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_addr_i(op_addr_i),
    .fix_mode_i(fix_mode_i), .indexed_i(indexed_i), .index_i(index_i),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
    .busy_o(busy_o), .done_o(done_o), .pc_o(pc_o)
  );

  always @(posedge clk) begin
    if (mem_rd_o) begin
      mem_data_i <= mem[mem_addr_o];
      reads      <= reads + 1;
    end
  end

  function automatic logic [15:0] exp_pc(logic [15:0] op, logic fx, logic ix, logic [7:0] idx);
    logic [15:0] p, ph;
    p = {mem[op + 16'd1], mem[op]};
    if (ix) p = p + {8'd0, idx};
    ph = (fx || ix) ? p + 16'd1 : {p[15:8], p[7:0] + 8'd1};
    return {mem[ph], mem[p]};
  endfunction

  function automatic int exp_lat(logic fx, logic ix);
    return 6 + ((fx || ix) ? 1 : 0) + (ix ? 1 : 0);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Runs one operation; if poke is set, a second start with other inputs arrives mid-run.
  task automatic run_op(string req, logic [15:0] op, logic fx, logic ix, logic [7:0] idx, bit poke);
    logic [15:0] e;
    int n;
    bit busy_ok;
    e = exp_pc(op, fx, ix, idx);
    @(negedge clk);
    start_i = 1'b1; op_addr_i = op; fix_mode_i = fx; indexed_i = ix; index_i = idx;
    reads = 0;
    @(negedge clk);
    start_i = 1'b0;
    n = 1;
    busy_ok = 1'b1;
    while (!done_o && n < 40) begin
      if (!busy_o) busy_ok = 1'b0;
      if (poke && n == 2) begin
        start_i = 1'b1; op_addr_i = op ^ 16'h5a5a; fix_mode_i = ~fx; indexed_i = ~ix; index_i = ~idx;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start_i = 1'b0;
    check({req, " pc"}, {16'd0, pc_o}, {16'd0, e});
    check("R7 latency", n, exp_lat(fx, ix));
    check("R8 busy during op", {31'd0, busy_ok}, 32'd1);
    check("R8 busy low at done", {31'd0, busy_o}, 32'd0);
    check("R11 four reads", reads, 4);
    @(negedge clk);
    check("R8 done one cycle", {31'd0, done_o}, 32'd0);
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] e1, e2;
    int n;
    void'($urandom(32'd1234));
    for (int a = 0; a < 65536; a++) mem[a] = 8'($urandom);
    mem[16'h0400] = 8'hFF; mem[16'h0401] = 8'h12;
    mem[16'h12FF] = 8'h34; mem[16'h1200] = 8'h56; mem[16'h1300] = 8'h78;
    mem[16'h0500] = 8'h00; mem[16'h0501] = 8'h20;
    mem[16'h20FF] = 8'hA1; mem[16'h2000] = 8'hB2; mem[16'h2100] = 8'hC3;
    mem[16'h0600] = 8'hF0; mem[16'h0601] = 8'h30;

    repeat (3) @(negedge clk);
    check("R1 busy in reset", {31'd0, busy_o}, 32'd0);
    check("R1 done in reset", {31'd0, done_o}, 32'd0);
    check("R1 rd in reset", {31'd0, mem_rd_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 busy idle", {31'd0, busy_o}, 32'd0);
    check("R1 done idle", {31'd0, done_o}, 32'd0);
    check("R1 rd idle", {31'd0, mem_rd_o}, 32'd0);

    // R4 legacy wrap: pointer 12FF -> upper from 1200
    run_op("R4", 16'h0400, 1'b0, 1'b0, 8'h00, 1'b0);
    check("R4 value", {16'd0, pc_o}, 32'h5634);
    // R5 corrected: upper from 1300
    run_op("R5", 16'h0400, 1'b1, 1'b0, 8'h00, 1'b0);
    check("R5 value", {16'd0, pc_o}, 32'h7834);
    // R6 table at 2000, index FF, legacy bit: reads 20FF and 2100
    run_op("R6", 16'h0500, 1'b0, 1'b1, 8'hFF, 1'b0);
    check("R6 value", {16'd0, pc_o}, 32'hC3A1);
    // R6 index carry 30F0+20 = 3110
    run_op("R6 carry", 16'h0600, 1'b1, 1'b1, 8'h20, 1'b0);
    check("R6 carry value", {16'd0, pc_o}, {16'd0, mem[16'h3111], mem[16'h3110]});
    // R2 operand fetch across FFFF, R3 general
    run_op("R2", 16'hFFFF, 1'b0, 1'b0, 8'h00, 1'b0);
    run_op("R3", 16'h1234, 1'b1, 1'b0, 8'h00, 1'b0);
    // R9 start while busy ignored
    run_op("R9", 16'h0400, 1'b0, 1'b0, 8'h00, 1'b1);
    check("R9 value", {16'd0, pc_o}, 32'h5634);
    run_op("R9 idx", 16'h0500, 1'b1, 1'b1, 8'hFF, 1'b1);

    // R10 back-to-back: start in the done cycle
    e1 = exp_pc(16'h0400, 1'b1, 1'b0, 8'h00);
    e2 = exp_pc(16'h0400, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    start_i = 1'b1; op_addr_i = 16'h0400; fix_mode_i = 1'b1; indexed_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    n = 1;
    while (!done_o && n < 40) begin @(negedge clk); n++; end
    check("R10 first pc", {16'd0, pc_o}, {16'd0, e1});
    start_i = 1'b1; op_addr_i = 16'h0400; fix_mode_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    n = 1;
    check("R10 accepted busy", {31'd0, busy_o}, 32'd1);
    while (!done_o && n < 40) begin @(negedge clk); n++; end
    check("R10 second pc", {16'd0, pc_o}, {16'd0, e2});
    check("R10 second latency", n, 6);

    for (int k = 0; k < 60; k++) begin
      logic [2:0] r;
      r = 3'($urandom);
      run_op("R3 random", 16'($urandom), r[0], r[1], 8'($urandom), r[2]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule